// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the execute stage of a small accumulator-style core. It holds the working register (W) and the status register. On each operation it combines W with a second operand, taken either from an immediate value or from a register-file read port. The decoder drives the opcode, the operand source, the destination choice and a bit index. The block returns the result combinationally in the same cycle, together with a file-write enable.

When `valid_i` is high, W (if it is the destination) and the flags are written on the next rising clock edge. Each opcode has its own mask that says which of carry, digit carry and zero it may change. Subtraction always computes operand minus W, so the carry and digit-carry flags report "no borrow". Rotates pass through the carry flag as a ninth bit.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0 (add) gives result = W + operand. Carry (status bit 0) is the ninth sum bit. Digit carry (status bit 1) is the carry out of bit 3. Zero (status bit 2) is set when the 8-bit result is 0.
- R2: Opcode 1 (subtract) gives result = operand − W for both the immediate and the file operand. Carry is 1 when operand ≥ W, and digit carry is 1 when operand[3:0] ≥ W[3:0]. Both read as 1 = no borrow. Zero is set as in R1.
- R3: Opcodes 2 AND, 3 OR and 4 XOR (each with W), and opcodes 5 increment, 6 decrement, 7 complement, 8 clear (result 0) and 9 move operand, change only the zero flag. Carry and digit carry keep their values.
- R4: Opcode 11 rotates left through carry: result = {op[6:0], C} and the new C = op[7]. Opcode 12 rotates right: result = {C, op[7:1]} and the new C = op[0]. Only carry changes.
- R5: Opcode 10 swaps the operand's nibbles. Opcode 15 returns W unchanged. Neither changes any flag.
- R6: Opcode 13 sets bit `bit_idx_i` of the operand and opcode 14 clears it. All other bits pass through, and no flag changes.
- R7: When `lit_sel_i` is 1 the operand is `lit_i`, otherwise it is `file_i`. When `dest_file_i` is 1, `file_we_o` follows `valid_i` and W keeps its value. Otherwise W loads the result on the clock edge.
- R8: While `valid_i` is low, W and the status register hold their values and `file_we_o` is 0.
- R9: An asynchronous active-low reset clears W and the status register. Status bits 7:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode (see R1–R6) |
| lit_sel_i | input | 1 | 1 selects the immediate operand |
| dest_file_i | input | 1 | 1 sends the result to the file, 0 to W |
| lit_i | input | 8 | Immediate operand |
| file_i | input | 8 | Register-file operand |
| bit_idx_i | input | 3 | Bit index for set and clear |
| result_o | output | 8 | Combinational result |
| file_we_o | output | 1 | File write enable |
| acc_o | output | 8 | Working register |
| status_o | output | 8 | Status: bit 0 carry, bit 1 digit carry, bit 2 zero |

## Verification
The vector table goes after the flag edges. One case is a half carry without a full carry (0x0F + 0x01). Another is a full carry with a zero result (0x80 + 0x80). A third is a subtract that borrows from both nibbles. A design with the subtract operands reversed, or with the borrow sense inverted, fails the carry checks on these cases. Before each vector, the carry and digit carry are preset to known values, so a mask that leaks shows up as a changed flag after a logic, increment or swap operation. Directed cases cover rotates with carry in and carry out, an idle strobe that must not disturb W, a file destination that must leave W alone, and reset in the middle of a run.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_AND  = 4'd2,  OP_OR   = 4'd3,
    OP_XOR  = 4'd4,  OP_INC  = 4'd5,  OP_DEC  = 4'd6,  OP_COM  = 4'd7,
    OP_CLR  = 4'd8,  OP_MOVF = 4'd9,  OP_SWAP = 4'd10, OP_RLC  = 4'd11,
    OP_RRC  = 4'd12, OP_BSET = 4'd13, OP_BCLR = 4'd14, OP_MOVW = 4'd15
  } alu_op_e;

  localparam int FLG_C   = 0;
  localparam int FLG_DC  = 1;
  localparam int FLG_Z   = 2;
  localparam int NUM_FLG = 3;

  // per-opcode set of flags allowed to change
  function automatic logic [NUM_FLG-1:0] flag_mask(alu_op_e op);
    logic [NUM_FLG-1:0] m;
    m = '0;
    unique case (op)
      OP_ADD, OP_SUB:                 m = '1;
      OP_AND, OP_OR, OP_XOR, OP_INC,
      OP_DEC, OP_COM, OP_CLR, OP_MOVF: m[FLG_Z] = 1'b1;
      OP_RLC, OP_RRC:                 m[FLG_C] = 1'b1;
      default:                        m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DW = 8,
  localparam int HW = DW / 2,
  localparam int IW = $clog2(DW)
) (
  input  alu_op_e               op_i,
  input  logic [DW-1:0]         w_i,
  input  logic [DW-1:0]         opnd_i,
  input  logic [IW-1:0]         bit_idx_i,
  input  logic                  c_i,
  output logic [DW-1:0]         res_o,
  output logic [NUM_FLG-1:0]    flg_o
);
  logic [DW:0] sum, diff;
  logic [HW:0] hsum, hdiff;
  logic        c_new, dc_new;

  always_comb begin
    sum   = {1'b0, w_i} + {1'b0, opnd_i};
    hsum  = {1'b0, w_i[HW-1:0]} + {1'b0, opnd_i[HW-1:0]};
    // operand - W as operand + ~W + 1; top bit is the no-borrow indication
    diff  = {1'b0, opnd_i} + {1'b0, ~w_i} + (DW+1)'(1);
    hdiff = {1'b0, opnd_i[HW-1:0]} + {1'b0, ~w_i[HW-1:0]} + (HW+1)'(1);
    res_o  = opnd_i;
    c_new  = c_i;
    dc_new = 1'b0;
    unique case (op_i)
      OP_ADD:  begin res_o = sum[DW-1:0];  c_new = sum[DW];  dc_new = hsum[HW];  end
      OP_SUB:  begin res_o = diff[DW-1:0]; c_new = diff[DW]; dc_new = hdiff[HW]; end
      OP_AND:  res_o = w_i & opnd_i;
      OP_OR:   res_o = w_i | opnd_i;
      OP_XOR:  res_o = w_i ^ opnd_i;
      OP_INC:  res_o = opnd_i + DW'(1);
      OP_DEC:  res_o = opnd_i - DW'(1);
      OP_COM:  res_o = ~opnd_i;
      OP_CLR:  res_o = '0;
      OP_MOVF: res_o = opnd_i;
      OP_SWAP: res_o = {opnd_i[HW-1:0], opnd_i[DW-1:HW]};
      OP_RLC:  begin res_o = {opnd_i[DW-2:0], c_i}; c_new = opnd_i[DW-1]; end
      OP_RRC:  begin res_o = {c_i, opnd_i[DW-1:1]}; c_new = opnd_i[0];    end
      OP_BSET: res_o[bit_idx_i] = 1'b1;
      OP_BCLR: res_o[bit_idx_i] = 1'b0;
      OP_MOVW: res_o = w_i;
      default: res_o = opnd_i;
    endcase
    flg_o         = '0;
    flg_o[FLG_C]  = c_new;
    flg_o[FLG_DC] = dc_new;
    flg_o[FLG_Z]  = (res_o == '0);
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_FLG-1:0] we_i,
  input  logic [NUM_FLG-1:0] flg_i,
  output logic [DW-1:0]      status_o
);
  logic [NUM_FLG-1:0] flg_q;

  for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flg_q[i] <= 1'b0;
      else if (we_i[i]) flg_q[i] <= flg_i[i];
    end
  end

  assign status_o = {{(DW-NUM_FLG){1'b0}}, flg_q};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic          lit_sel_i,
  input  logic          dest_file_i,
  input  logic [DW-1:0] lit_i,
  input  logic [DW-1:0] file_i,
  input  logic [IW-1:0] bit_idx_i,
  output logic [DW-1:0] result_o,
  output logic          file_we_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] status_o
);
  alu_op_e            op;
  logic [DW-1:0]      opnd, w_q, res;
  logic [NUM_FLG-1:0] flg_new, flg_we;

  assign op   = alu_op_e'(op_i);
  assign opnd = lit_sel_i ? lit_i : file_i;

  acc_alu_dp #(.DW(DW)) u_dp (
    .op_i      (op),
    .w_i       (w_q),
    .opnd_i    (opnd),
    .bit_idx_i (bit_idx_i),
    .c_i       (status_o[FLG_C]),
    .res_o     (res),
    .flg_o     (flg_new)
  );

  assign flg_we = flag_mask(op) & {NUM_FLG{valid_i}};

  acc_alu_flags #(.DW(DW)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (flg_we),
    .flg_i    (flg_new),
    .status_o (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     w_q <= '0;
    else if (valid_i && !dest_file_i) w_q <= res;
  end

  assign result_o  = res;
  assign file_we_o = valid_i & dest_file_i;
  assign acc_o     = w_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic [DW-1:0] result_o,
  input logic          file_we_o,
  input logic [DW-1:0] acc_o,
  input logic [DW-1:0] status_o
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_o) && $stable(status_o))) else $error("idle changed state"); // R8
  AST_IDLE_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !file_we_o) else $error("file write while idle"); // R8
  AST_FILE_DEST_KEEPS_W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    file_we_o |=> $stable(acc_o)) else $error("W changed on file dest"); // R7
  AST_W_LOADS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !file_we_o) |=> acc_o == $past(result_o)) else $error("W not loaded"); // R7
  AST_ROT_ONLY_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd11 || op_i == 4'd12)) |=> status_o[DW-1:1] == $past(status_o[DW-1:1]))
    else $error("rotate touched non-carry flag"); // R4
  AST_LOGIC_KEEPS_C_DC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 4'd2 && op_i <= 4'd9) |=> status_o[1:0] == $past(status_o[1:0]))
    else $error("zero-only op touched carry"); // R3
  AST_SWAP_MOVW_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd10 || op_i == 4'd15)) |=> $stable(status_o))
    else $error("swap or W move changed flags"); // R5
  AST_BIT_OPS_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd13 || op_i == 4'd14)) |=> $stable(status_o))
    else $error("bit op changed flags"); // R6
  AST_UPPER_STATUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[DW-1:3] == '0) else $error("status upper bits set"); // R9
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .file_we_o (file_we_o),
  .acc_o     (acc_o),
  .status_o  (status_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic       lit_sel_i = 1'b0;
  logic       dest_file_i = 1'b0;
  logic [7:0] lit_i = '0;
  logic [7:0] file_i = '0;
  logic [2:0] bit_idx_i = '0;
  logic [7:0] result_o, acc_o, status_o;
  logic       file_we_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] res_s;
  logic       we_s;

  always #10 clk_i = ~clk_i;

  acc_alu u_acc_alu (.*);

  typedef struct packed {
    logic [3:0] op;
    logic       lit;
    logic       dest;
    logic [7:0] opnd;
    logic [2:0] idx;
    logic [7:0] w;
    logic       c;
    logic [7:0] res;
    logic [2:0] zdcc;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b1, 1'b0, 8'h0F, 3'd0, 8'h01, 1'b0, 8'h10, 3'b010},
    '{4'd0,  1'b0, 1'b1, 8'h80, 3'd0, 8'h80, 1'b0, 8'h00, 3'b101},
    '{4'd0,  1'b1, 1'b0, 8'h3A, 3'd0, 8'h45, 1'b1, 8'h7F, 3'b000},
    '{4'd1,  1'b1, 1'b0, 8'h10, 3'd0, 8'h01, 1'b0, 8'h0F, 3'b001},
    '{4'd1,  1'b0, 1'b1, 8'h05, 3'd0, 8'h05, 1'b0, 8'h00, 3'b111},
    '{4'd1,  1'b1, 1'b0, 8'h02, 3'd0, 8'h03, 1'b1, 8'hFF, 3'b000},
    '{4'd2,  1'b1, 1'b0, 8'hF0, 3'd0, 8'h0F, 1'b1, 8'h00, 3'b111},
    '{4'd3,  1'b0, 1'b0, 8'h50, 3'd0, 8'h0A, 1'b0, 8'h5A, 3'b010},
    '{4'd4,  1'b1, 1'b1, 8'hAA, 3'd0, 8'hAA, 1'b1, 8'h00, 3'b111},
    '{4'd5,  1'b0, 1'b1, 8'hFF, 3'd0, 8'h33, 1'b0, 8'h00, 3'b110},
    '{4'd6,  1'b0, 1'b0, 8'h01, 3'd0, 8'h22, 1'b1, 8'h00, 3'b111},
    '{4'd7,  1'b0, 1'b0, 8'h0F, 3'd0, 8'h10, 1'b0, 8'hF0, 3'b010},
    '{4'd8,  1'b0, 1'b1, 8'h77, 3'd0, 8'h10, 1'b1, 8'h00, 3'b111},
    '{4'd9,  1'b0, 1'b0, 8'h00, 3'd0, 8'h55, 1'b0, 8'h00, 3'b110},
    '{4'd10, 1'b0, 1'b0, 8'hA5, 3'd0, 8'h00, 1'b0, 8'h5A, 3'b110},
    '{4'd11, 1'b0, 1'b1, 8'h81, 3'd0, 8'h01, 1'b0, 8'h02, 3'b011},
    '{4'd12, 1'b0, 1'b0, 8'h01, 3'd0, 8'h00, 1'b1, 8'h80, 3'b111},
    '{4'd12, 1'b0, 1'b0, 8'h02, 3'd0, 8'h07, 1'b1, 8'h81, 3'b010},
    '{4'd11, 1'b1, 1'b1, 8'h00, 3'd0, 8'h01, 1'b1, 8'h01, 3'b010},
    '{4'd13, 1'b0, 1'b1, 8'h00, 3'd7, 8'h01, 1'b0, 8'h80, 3'b010},
    '{4'd14, 1'b0, 1'b0, 8'hFF, 3'd0, 8'h00, 1'b1, 8'hFE, 3'b111},
    '{4'd15, 1'b0, 1'b1, 8'h00, 3'd0, 8'h99, 1'b0, 8'h99, 3'b010}
  };

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0:                  return "R1";
      4'd1:                  return "R2";
      4'd10, 4'd15:          return "R5";
      4'd11, 4'd12:          return "R4";
      4'd13, 4'd14:          return "R6";
      default:               return "R3";
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, capture combinational outputs mid-cycle, drop strobe after the edge
  task automatic step(logic v, logic [3:0] op, logic lit, logic dest,
                      logic [7:0] opnd, logic [2:0] idx);
    @(negedge clk_i);
    valid_i = v; op_i = op; lit_sel_i = lit; dest_file_i = dest; bit_idx_i = idx;
    lit_i  = lit ? opnd : ~opnd;
    file_i = lit ? ~opnd : opnd;
    #5;
    res_s = result_o;
    we_s  = file_we_o;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
  endtask

  // leaves C = c, DC = 1, Z = (w == 0), W = w
  task automatic prep(logic [7:0] w, logic c);
    step(1'b1, 4'd9, 1'b1, 1'b0, 8'h00, 3'd0);
    step(1'b1, 4'd1, 1'b1, 1'b0, 8'h00, 3'd0);
    if (!c) step(1'b1, 4'd12, 1'b1, 1'b1, 8'h00, 3'd0);
    step(1'b1, 4'd9, 1'b1, 1'b0, w, 3'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #25;
    check("R9", "acc in reset", acc_o, 8'h00);
    check("R9", "status in reset", status_o, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      prep(v.w, v.c);
      step(1'b1, v.op, v.lit, v.dest, v.opnd, v.idx);
      check(req_of(v.op), "result", res_s, v.res);
      check(req_of(v.op), "flags z/dc/c", {5'd0, status_o[2:0]}, {5'd0, v.zdcc});
      check("R7", "file write enable", {7'd0, we_s}, {7'd0, v.dest});
      check("R7", "acc after op", acc_o, v.dest ? v.w : v.res);
      check("R9", "status upper bits", {3'd0, status_o[7:3]}, 8'h00);
    end

    // R8: idle strobe with an op that would change W and all flags
    prep(8'h33, 1'b0);
    step(1'b0, 4'd0, 1'b1, 1'b0, 8'hFF, 3'd0);
    check("R8", "file write while idle", {7'd0, we_s}, 8'h00);
    check("R8", "acc held while idle", acc_o, 8'h33);
    check("R8", "status held while idle", status_o, 8'h02);
    step(1'b0, 4'd0, 1'b0, 1'b1, 8'hFF, 3'd0);
    check("R8", "file write while idle, file dest", {7'd0, we_s}, 8'h00);

    // R6: clear bit 3 with literal operand
    step(1'b1, 4'd14, 1'b1, 1'b0, 8'hFF, 3'd3);
    check("R6", "bit clear idx 3", acc_o, 8'hF7);
    check("R6", "bit clear flags", status_o, 8'h02);

    // R9: reset in the middle of a run
    prep(8'h5A, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #3;
    check("R9", "acc after async reset", acc_o, 8'h00);
    check("R9", "status after async reset", status_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule